// File: doc/BRIEF.md
# Hotspot-Driven Two-Wire EEPROM Line Controller

This block sits on a cartridge address bus and drives the clock and data lines of a two-wire serial EEPROM. The host CPU never writes a data register. It moves the lines only by reading a small set of hotspot addresses. Each such read starts one fixed line action: a clock pulse, a clock pulse with a data inversion inside it, a data-level set, or a data-line sample. The block never produces a bus edge unless a CPU access asks for it.

The CPU learns the data-line level without any readable register. A sample read that finds the line low asserts a one-bit modifier. The surrounding bank logic uses this bit to invert bit 8 of the upper bank number, so the level shows up as a change in which bytes the next access returns. The EEPROM clock pin is also address line A14. Because of this, every hotspot decode compares the full 15-bit address, A14 included, so a hotspot only fires when the A14 level matches the clock state the action expects.

Timing inside the block runs on a fast internal clock. Every multi-step action is split into phases of `PHASE_CYC` internal cycles each, so the data line only changes while the clock is held high and never on a clock edge.

Top module: `hotspot_i2c_pins`

## Requirements
- R1: After a synchronous active-low reset, `scl_out` is 0, `sda_oe` is 0 (the data line is released), and `bank_flip` is 0.
- R2: An access to address 0x7FFF drives `scl_out` to 1 from the first clock edge that samples `bus_valid` high, for exactly `PHASE_CYC` cycles, and then back to 0. `sda_oe` does not change.
- R3: An access to address 0x7FFE raises `scl_out` at the first edge for 2×`PHASE_CYC` cycles. After the first `PHASE_CYC` cycles it inverts the driven data level (`sda_oe` toggles) while the clock stays high. It then lowers the clock.
- R4: An access to 0x0073 sets `sda_oe`=0 (line released high). An access to 0x0072 sets `sda_oe`=1 (line driven low). Both take effect at the first edge and leave `scl_out` unchanged.
- R5: An access to 0x0071 samples `sda_in` at the first edge. If the sampled value is 0, `bank_flip` becomes 1. If it is 1, `bank_flip` stays 0. The sample reads the wire, not the block's own drive.
- R6: Once set, `bank_flip` stays 1 through the whole next bus access and returns to 0 in the cycle after that access ends (`bus_valid` falls).
- R7: Decoding compares all 15 address bits, including A14. Addresses that differ from a hotspot in any bit, for example 0x3FFF or 0x4073, change neither line.
- R8: Each access fires its action once, however many cycles `bus_valid` stays high with the address held.
- R9: A new access that starts while a clock sequence from R2 or R3 is still running is ignored for line control.
- R10: The data line is open-drain. The block only outputs a pull-low enable and never drives a high level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal fast clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 15 | Cartridge address bus, A14 is bit 14 |
| bus_valid | input | 1 | High for the duration of one CPU bus access |
| sda_in | input | 1 | Sampled level of the EEPROM data wire |
| scl_out | output | 1 | EEPROM clock line |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| bank_flip | output | 1 | 1 inverts bank bit 8 for the next access |

## Verification
The bench records the clock and data lines cycle by cycle after each hotspot access and compares them with the expected phase pattern. A design that toggled data at the same edge as the clock, or in the wrong order, would show a data change outside the clock-high window. A design that retriggered on a held address would show a second clock pulse. The bench probes aliased addresses that differ only in A14; a decoder that ignored that bit would produce a stray clock pulse. It also issues an access in the middle of a sequence, and checks that the bank modifier both reflects an externally pulled-low line and lasts exactly one further access. A design that sampled its own drive, or cleared the modifier too early, fails these checks.

// File: rtl/hotspot_pkg.sv
// Package: shared action codes and sequencer states for the hotspot
// line controller. Assumes nothing beyond standard synthesizable types.
package hotspot_pkg;

    typedef enum logic [2:0] {
        ACT_NONE   = 3'd0,
        ACT_PULSE  = 3'd1,
        ACT_TOGGLE = 3'd2,
        ACT_SET_HI = 3'd3,
        ACT_SET_LO = 3'd4,
        ACT_SAMPLE = 3'd5
    } hs_act_e;

    typedef enum logic [2:0] {
        S_IDLE     = 3'd0,
        S_PULSE_HI = 3'd1,
        S_TOG_HI   = 3'd2,
        S_TOG_FLIP = 3'd3
    } seq_state_e;

endpackage

// File: rtl/access_edge.sv
// Module: access_edge
// Turns the level bus strobe into one-cycle start and finish pulses so that
// every CPU access is seen exactly once. Assumes bus_valid is synchronous.
module access_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic valid_i,
    output logic start_o,
    output logic finish_o
);

    logic valid_q;

    // Purpose: remember the strobe level of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) valid_q <= 1'b0;
        else        valid_q <= valid_i;
    end

    // Purpose: derive start and finish pulses from the strobe edges.
    always_comb begin
        start_o  = valid_i & ~valid_q;
        finish_o = ~valid_i & valid_q;
    end

    // R8: an access can only start once; there is never a start in two cycles in a row.
    assert_single_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);

endmodule

// File: rtl/hotspot_decode.sv
// Module: hotspot_decode
// Maps the full cartridge address onto a line action. Every bit, A14
// included, is compared so aliases never fire. Purely combinational.
module hotspot_decode
    import hotspot_pkg::*;
#(
    parameter int          ADDR_W     = 15,
    parameter logic [14:0] ADR_PULSE  = 15'h7FFF,
    parameter logic [14:0] ADR_TOGGLE = 15'h7FFE,
    parameter logic [14:0] ADR_SET_HI = 15'h0073,
    parameter logic [14:0] ADR_SET_LO = 15'h0072,
    parameter logic [14:0] ADR_SAMPLE = 15'h0071
) (
    input  logic [ADDR_W-1:0] addr_i,
    output hs_act_e           act_o
);

    localparam int NHOT = 5;

    logic [NHOT-1:0][ADDR_W-1:0] hot_adr;
    hs_act_e                     hot_act [NHOT];
    logic [NHOT-1:0]             hit;

    assign hot_adr[0] = ADDR_W'(ADR_PULSE);
    assign hot_adr[1] = ADDR_W'(ADR_TOGGLE);
    assign hot_adr[2] = ADDR_W'(ADR_SET_HI);
    assign hot_adr[3] = ADDR_W'(ADR_SET_LO);
    assign hot_adr[4] = ADDR_W'(ADR_SAMPLE);
    assign hot_act[0] = ACT_PULSE;
    assign hot_act[1] = ACT_TOGGLE;
    assign hot_act[2] = ACT_SET_HI;
    assign hot_act[3] = ACT_SET_LO;
    assign hot_act[4] = ACT_SAMPLE;

    // Purpose: compare the address against each hotspot in parallel.
    for (genvar g = 0; g < NHOT; g++) begin : g_cmp
        assign hit[g] = (addr_i == hot_adr[g]);
    end

    // Purpose: select the action of the matching hotspot (at most one matches).
    always_comb begin
        act_o = ACT_NONE;
        for (int i = 0; i < NHOT; i++) begin
            if (hit[i]) act_o = hot_act[i];
        end
    end

    // R7: distinct hotspot addresses can never match together.
    assert_onehot_hit_R7: assert final ($onehot0(hit));

endmodule

// File: rtl/line_sequencer.sv
// Module: line_sequencer
// Runs the clock and data line actions. Clock sequences are split into
// phases of PHASE_CYC cycles; data only moves while the clock is high.
// Assumes PHASE_CYC >= 1. Starts arriving while busy are dropped.
module line_sequencer
    import hotspot_pkg::*;
#(
    parameter int PHASE_CYC = 2
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    start_i,
    input  hs_act_e act_i,
    output logic    scl_o,
    output logic    sda_oe_o
);

    localparam int CNT_W = $clog2(PHASE_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PHASE_CYC - 1);

    seq_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             scl_q;
    logic             oe_q;
    logic             phase_done;
    logic             accept;

    // Purpose: a phase ends when its counter has run down.
    assign phase_done = (cnt_q == '0);
    // Purpose: only an idle sequencer takes a new access.
    assign accept     = start_i && (state_q == S_IDLE);

    // Purpose: phase state machine with clock and data line registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
            scl_q   <= 1'b0;
            oe_q    <= 1'b0;
        end else begin
            case (state_q)
                S_IDLE: begin
                    if (accept) begin
                        case (act_i)
                            ACT_PULSE: begin
                                state_q <= S_PULSE_HI;
                                scl_q   <= 1'b1;
                                cnt_q   <= CNT_LOAD;
                            end
                            ACT_TOGGLE: begin
                                state_q <= S_TOG_HI;
                                scl_q   <= 1'b1;
                                cnt_q   <= CNT_LOAD;
                            end
                            ACT_SET_HI: oe_q <= 1'b0;
                            ACT_SET_LO: oe_q <= 1'b1;
                            default:    ;
                        endcase
                    end
                end
                S_PULSE_HI: begin
                    if (phase_done) begin
                        state_q <= S_IDLE;
                        scl_q   <= 1'b0;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                S_TOG_HI: begin
                    if (phase_done) begin
                        state_q <= S_TOG_FLIP;
                        oe_q    <= ~oe_q;
                        cnt_q   <= CNT_LOAD;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                S_TOG_FLIP: begin
                    if (phase_done) begin
                        state_q <= S_IDLE;
                        scl_q   <= 1'b0;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign scl_o    = scl_q;
    assign sda_oe_o = oe_q;

    // R2 R3: the clock only rises one cycle after an access start.
    assert_scl_rise_from_access_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_q) |-> $past(start_i));

    // R3: a data change with the clock high on both sides is the mid-pulse inversion.
    assert_sda_moves_inside_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_q && $past(scl_q) && (oe_q != $past(oe_q))) |-> (state_q == S_TOG_FLIP));

    // R9: a start that arrives while busy does not restart the phase counter.
    assert_busy_ignores_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && state_q == S_PULSE_HI && !phase_done) |=> (state_q == S_PULSE_HI));

endmodule

// File: rtl/bank_flip_ctrl.sv
// Module: bank_flip_ctrl
// Holds the bank-bit modifier. A sample access that sees a low wire arms it;
// it lasts through the next whole access and clears when that access ends.
module bank_flip_ctrl
    import hotspot_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    start_i,
    input  logic    finish_i,
    input  hs_act_e act_i,
    input  logic    sda_i,
    output logic    flip_o
);

    logic flip_q;
    logic used_q;

    // Purpose: set on a low sample, mark use on the next access, clear at its end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flip_q <= 1'b0;
            used_q <= 1'b0;
        end else if (start_i && act_i == ACT_SAMPLE && !flip_q) begin
            flip_q <= ~sda_i;
            used_q <= 1'b0;
        end else if (start_i && flip_q) begin
            used_q <= 1'b1;
        end else if (finish_i && used_q) begin
            flip_q <= 1'b0;
            used_q <= 1'b0;
        end
    end

    assign flip_o = flip_q;

    // R5: the modifier only rises after a sample access saw a low wire.
    assert_flip_needs_low_sample_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flip_q) |-> $past(start_i && act_i == ACT_SAMPLE && !sda_i));

    // R6: the modifier only falls at the end of an access.
    assert_flip_clears_at_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flip_q) |-> $past(finish_i));

endmodule

// File: rtl/hotspot_i2c_pins.sv
// Module: hotspot_i2c_pins (top)
// Drives a two-wire EEPROM clock and open-drain data enable purely from
// reads of hotspot addresses, and reports the wire level via a bank-bit
// modifier. Assumes bus_valid is synchronous to clk and high once per access.
module hotspot_i2c_pins
    import hotspot_pkg::*;
#(
    parameter int ADDR_W    = 15,
    parameter int PHASE_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_valid,
    input  logic              sda_in,
    output logic              scl_out,
    output logic              sda_oe,
    output logic              bank_flip
);

    logic    acc_start;
    logic    acc_finish;
    hs_act_e act;

    access_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid_i  (bus_valid),
        .start_o  (acc_start),
        .finish_o (acc_finish)
    );

    hotspot_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr_i (bus_addr),
        .act_o  (act)
    );

    line_sequencer #(.PHASE_CYC(PHASE_CYC)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (acc_start),
        .act_i    (act),
        .scl_o    (scl_out),
        .sda_oe_o (sda_oe)
    );

    bank_flip_ctrl u_flip (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (acc_start),
        .finish_i (acc_finish),
        .act_i    (act),
        .sda_i    (sda_in),
        .flip_o   (bank_flip)
    );

    // R1 R10: with no access since reset, the clock is low and the line is released.
    assert_quiet_lines_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!rst_n)) |-> (!scl_out && !sda_oe && !bank_flip));

endmodule

// File: tb/sim_hotspot_i2c_pins.sv
// Directed bench for hotspot_i2c_pins: one task per scenario.
module sim_hotspot_i2c_pins;

    localparam int CLK_PERIOD = 10;
    localparam int PH         = 2;
    localparam int NCAP       = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [14:0] bus_addr = '0;
    logic        bus_valid = 1'b0;
    logic        eep_low = 1'b0;
    logic        sda_in;
    logic        scl_out, sda_oe, bank_flip;

    int errors = 0;
    int checks = 0;
    logic cap_scl [NCAP];
    logic cap_oe  [NCAP];

    // Wire model: pulled up, low if either side pulls it low.
    assign sda_in = ~(sda_oe | eep_low);

    always #(CLK_PERIOD/2) clk = ~clk;

    hotspot_i2c_pins #(.ADDR_W(15), .PHASE_CYC(PH)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_valid(bus_valid),
        .sda_in(sda_in), .scl_out(scl_out), .sda_oe(sda_oe), .bank_flip(bank_flip)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Access held for 3 cycles; captures lines after each of NCAP edges.
    task automatic access_capture(input logic [14:0] a);
        @(negedge clk);
        bus_addr  = a;
        bus_valid = 1'b1;
        for (int c = 0; c < NCAP; c++) begin
            @(posedge clk); #1;
            cap_scl[c] = scl_out;
            cap_oe[c]  = sda_oe;
            if (c == 2) bus_valid = 1'b0;
        end
        idle(2);
    endtask

    task automatic t_reset;
        check("R1", "scl after reset", scl_out, 1'b0);
        check("R1", "sda_oe after reset", sda_oe, 1'b0);
        check("R1", "bank_flip after reset", bank_flip, 1'b0);
    endtask

    task automatic t_set_levels;
        access_capture(15'h0072);
        check("R4", "0x72 drives low", sda_oe, 1'b1);
        check("R10", "line low by enable", sda_in, 1'b0);
        for (int c = 0; c < NCAP; c++) check("R4", "0x72 clock untouched", cap_scl[c], 1'b0);
        access_capture(15'h0073);
        check("R4", "0x73 releases", sda_oe, 1'b0);
        check("R10", "line high when released", sda_in, 1'b1);
    endtask

    task automatic t_pulse;
        logic oe0;
        oe0 = sda_oe;
        access_capture(15'h7FFF);
        for (int c = 0; c < NCAP; c++) begin
            check("R2", $sformatf("pulse scl cycle %0d", c), cap_scl[c], (c < PH) ? 1'b1 : 1'b0);
            check("R8", $sformatf("single pulse sda cycle %0d", c), cap_oe[c], oe0);
        end
    endtask

    task automatic t_toggle;
        logic oe0;
        oe0 = sda_oe;
        access_capture(15'h7FFE);
        for (int c = 0; c < NCAP; c++) begin
            check("R3", $sformatf("toggle scl cycle %0d", c), cap_scl[c], (c < 2*PH) ? 1'b1 : 1'b0);
            check("R3", $sformatf("toggle sda cycle %0d", c), cap_oe[c], (c < PH) ? oe0 : ~oe0);
        end
    endtask

    task automatic t_alias;
        logic oe0;
        oe0 = sda_oe;
        access_capture(15'h3FFF);
        for (int c = 0; c < NCAP; c++) check("R7", "0x3FFF no clock", cap_scl[c], 1'b0);
        access_capture(15'h4072);
        check("R7", "0x4072 no data change", sda_oe, oe0);
        access_capture(15'h4071);
        check("R7", "0x4071 no sample", bank_flip, 1'b0);
    endtask

    task automatic t_sample;
        // Line high: no flip.
        access_capture(15'h0073);
        access_capture(15'h0071);
        check("R5", "high line no flip", bank_flip, 1'b0);
        // EEPROM pulls low while block releases: flip.
        eep_low = 1'b1;
        access_capture(15'h0071);
        eep_low = 1'b0;
        check("R5", "low wire flips", bank_flip, 1'b1);
        // Next access: held throughout, clears after it ends.
        @(negedge clk);
        bus_addr  = 15'h1234;
        bus_valid = 1'b1;
        for (int c = 0; c < 3; c++) begin
            @(posedge clk); #1;
            check("R6", "flip held during next access", bank_flip, 1'b1);
        end
        @(negedge clk);
        bus_valid = 1'b0;
        @(posedge clk); #1;
        check("R6", "flip cleared after next access", bank_flip, 1'b0);
        idle(2);
    endtask

    task automatic t_busy;
        access_capture(15'h0072);
        // Toggle (low->released), then a 0x72 access starts mid-sequence.
        @(negedge clk);
        bus_addr  = 15'h7FFE;
        bus_valid = 1'b1;
        @(negedge clk);
        bus_valid = 1'b0;
        @(negedge clk);
        bus_addr  = 15'h0072;
        bus_valid = 1'b1;
        @(negedge clk);
        bus_valid = 1'b0;
        idle(8);
        check("R9", "overlapping 0x72 ignored", sda_oe, 1'b0);
        check("R9", "clock back low", scl_out, 1'b0);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 20000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        idle(4);
        @(negedge clk);
        rst_n = 1'b1;
        idle(1);
        t_reset;
        t_set_levels;
        t_pulse;
        t_toggle;
        t_toggle;
        t_alias;
        t_sample;
        t_busy;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule